// File: doc/BRIEF.md
# Sample-Granular Parallel Delay with Polarity Swap

This block sits at the end of a wide sample datapath. Each clock it takes one vector of 16 signed 16-bit samples on each of two paths, A and B. Lane 0 of a vector is the oldest sample in time order. Each path is delayed by a programmable number of individual samples, from 0 to 15. Because that is always less than one full vector, the block keeps the previous vector of each path. It then builds each output vector as a 16-sample window cut from the 32-sample join of the previous and the current vector.

After the delay, an optional polarity swap replaces every sample with its two's complement negation. This has the same effect as exchanging the two legs of a differential converter output. The negation of the most negative code saturates to the most positive code. Both paths share the delay select and the polarity control. One register stage sits between the inputs and the outputs.

Top module: `sample_delay_inv`

## Requirements
- R1: While `rst_n` is low, both output vectors are all zero, whatever the inputs are. After reset is released, the stored previous vector of each path reads as all-zero samples.
- R2: With `dly_sel` = 0 and `inv_en` = 0, each output vector equals the input vector of that path from the preceding clock, lane for lane.
- R3: With `dly_sel` = d, output lane k equals sample number 16·n + k − d of that path's sample stream. Here n counts vectors and lane j of vector n is sample 16·n + j. Lanes k < d therefore come from lanes 16 + k − d of the previous vector.
- R4: The largest delay, `dly_sel` = 15, places lanes 1 to 15 of the previous vector in output lanes 0 to 14, and lane 0 of the current vector in output lane 15.
- R5: Paths A and B use the same delay, but samples never cross between the paths.
- R6: With `inv_en` = 1, every output sample is the two's complement negation of the sample that the delay alone would give.
- R7: Negating −32768 (16'h8000) gives +32767 (16'h7FFF). No other value saturates.
- R8: A new `dly_sel` value applies to the output produced at the very next clock edge. That output uses the stored previous vector, so the output stream stays continuous when the delay changes every clock.
- R9: `inv_en` is sampled at the same edge as the data it applies to. Toggling it every clock flips the polarity of exactly the matching output vectors.
- R10: Latency from the inputs to the outputs is exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-vector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_sel | input | 4 | Delay in samples, 0 to 15 |
| inv_en | input | 1 | 1 = negate every output sample |
| a_in | input | 256 | Path A input vector, lane k at bits [16k+15:16k] |
| b_in | input | 256 | Path B input vector, lane k at bits [16k+15:16k] |
| a_out | output | 256 | Path A delayed and optionally negated vector |
| b_out | output | 256 | Path B delayed and optionally negated vector |

## Verification
The reference model keeps the full sample history of each path as a flat queue and indexes it by absolute sample number. A design that reversed the lane order, used the wrong half of the previous vector, or was off by one in the window would fail at once on ramp data at every delay from 1 to 15.

The delay select and the polarity control are also changed on every clock. This exposes a design that applied them one clock late, or that lost the previous vector when the delay changed. Streams of full-scale and negative-full-scale samples under inversion catch a negation that wraps −32768 back onto itself. A path that carries a constant while the other carries random data shows any mixing between the paths.

// File: rtl/lanedly_pkg.sv
package lanedly_pkg;

    localparam int DEF_LANES    = 16;
    localparam int DEF_SAMPLE_W = 16;

    typedef enum logic {
        POL_KEEP = 1'b0,
        POL_SWAP = 1'b1
    } pol_e;

endpackage

// File: rtl/lanedly_window.sv
// Picks a LANES-sample window out of {current, previous}; lane 0 is oldest.
module lanedly_window #(
    parameter int LANES = 16,
    parameter int SW    = 16,
    parameter int DW    = $clog2(LANES)
) (
    input  logic [LANES*SW-1:0] prev_vec,
    input  logic [LANES*SW-1:0] cur_vec,
    input  logic [DW-1:0]       shift,
    output logic [LANES*SW-1:0] win_vec
);
    localparam int VW = LANES * SW;

    logic [2*VW-1:0] joined;

    // Lanes 0..LANES-1 of the join hold the previous vector, the rest the current one.
    assign joined = {cur_vec, prev_vec};

    // R3: output lane k takes joined lane LANES + k - shift.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            win_vec[k*SW +: SW] = joined[(LANES + k - int'(shift))*SW +: SW];
        end
    end

endmodule

// File: rtl/lanedly_negate.sv
// Per-lane saturating two's complement negation.
module lanedly_negate
    import lanedly_pkg::*;
#(
    parameter int LANES = 16,
    parameter int SW    = 16
) (
    input  logic                inv,
    input  logic [LANES*SW-1:0] din,
    output logic [LANES*SW-1:0] dout
);
    localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};

    pol_e pol;
    assign pol = pol_e'(inv);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [SW-1:0] lane_in;
        logic signed [SW-1:0] lane_out;

        assign lane_in = din[k*SW +: SW];

        always_comb begin
            if (pol == POL_SWAP) begin
                lane_out = (lane_in == S_MIN) ? S_MAX : -lane_in;   // R6, R7
            end else begin
                lane_out = lane_in;
            end
        end

        assign dout[k*SW +: SW] = lane_out;

        // R7: the only value that cannot be negated exactly clips to the top code.
        always_comb begin
            if (inv === 1'b1 && lane_in === S_MIN) begin
                p_neg_saturate_r7 : assert (lane_out == S_MAX)
                    else $error("R7: negated minimum did not saturate");
            end
        end
    end

endmodule

// File: rtl/lanedly_path.sv
// One path: previous-vector store, window, polarity, output register.
module lanedly_path #(
    parameter int LANES = 16,
    parameter int SW    = 16,
    parameter int DW    = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       dly,
    input  logic                inv,
    input  logic [LANES*SW-1:0] din,
    output logic [LANES*SW-1:0] dout
);
    localparam int VW = LANES * SW;
    localparam logic [DW-1:0] DLY_MAX = DW'(LANES - 1);
    localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};

    typedef struct packed {
        logic [VW-1:0] prev;
        logic [VW-1:0] outv;
        logic [1:0]    age;
    } path_st_t;

    path_st_t st_d, st_q;

    logic [VW-1:0] win_w;
    logic [VW-1:0] pol_w;

    lanedly_window #(
        .LANES (LANES),
        .SW    (SW),
        .DW    (DW)
    ) i_window (
        .prev_vec (st_q.prev),
        .cur_vec  (din),
        .shift    (dly),
        .win_vec  (win_w)
    );

    lanedly_negate #(
        .LANES (LANES),
        .SW    (SW)
    ) i_negate (
        .inv  (inv),
        .din  (win_w),
        .dout (pol_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = din;            // R8: kept whatever the delay is
        st_d.outv = pol_w;          // R10: single register stage
        st_d.age  = (st_q.age == 2'd3) ? 2'd3 : st_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;             // R1
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.outv;

    logic signed [SW-1:0] din_l0, din_l1, out_l0;
    assign din_l0 = din[SW-1:0];
    assign din_l1 = din[2*SW-1:SW];
    assign out_l0 = dout[SW-1:0];

    // R2, R10: with zero delay the output is last clock's input.
    p_zero_delay_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age != 2'd0 && $past(dly) == '0 && !$past(inv)) |-> (dout == $past(din)));

    // R4: at the largest delay, output lane 0 is lane 1 of the vector two clocks back.
    p_full_delay_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age >= 2'd2 && $past(dly) == DLY_MAX && !$past(inv)) |-> (out_l0 == $past(din_l1, 2)));

    // R6: inversion gives the exact negation of every value except the minimum.
    p_negate_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age != 2'd0 && $past(dly) == '0 && $past(inv) && $past(din_l0) != S_MIN)
        |-> (out_l0 == -$past(din_l0)));

endmodule

// File: rtl/sample_delay_inv.sv
module sample_delay_inv
    import lanedly_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int SW    = DEF_SAMPLE_W,
    parameter int DW    = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       dly_sel,
    input  logic                inv_en,
    input  logic [LANES*SW-1:0] a_in,
    input  logic [LANES*SW-1:0] b_in,
    output logic [LANES*SW-1:0] a_out,
    output logic [LANES*SW-1:0] b_out
);
    localparam int VW    = LANES * SW;
    localparam int NPATH = 2;

    logic [VW-1:0] path_in  [NPATH];
    logic [VW-1:0] path_out [NPATH];

    assign path_in[0] = a_in;
    assign path_in[1] = b_in;

    // R5: identical, separate paths sharing only the controls.
    for (genvar g = 0; g < NPATH; g++) begin : g_path
        lanedly_path #(
            .LANES (LANES),
            .SW    (SW),
            .DW    (DW)
        ) i_path (
            .clk   (clk),
            .rst_n (rst_n),
            .dly   (dly_sel),
            .inv   (inv_en),
            .din   (path_in[g]),
            .dout  (path_out[g])
        );
    end

    assign a_out = path_out[0];
    assign b_out = path_out[1];

endmodule

// File: tb/test_sample_delay_inv.sv
module test_sample_delay_inv;
    localparam int LANES = 16;
    localparam int SW    = 16;
    localparam int VW    = LANES * SW;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic [3:0]    dly_sel = '0;
    logic          inv_en  = 1'b0;
    logic [VW-1:0] a_in    = '0;
    logic [VW-1:0] b_in    = '0;
    logic [VW-1:0] a_out;
    logic [VW-1:0] b_out;

    always #2 clk = ~clk;   // 250 MHz

    sample_delay_inv i_sample_delay_inv (
        .clk     (clk),
        .rst_n   (rst_n),
        .dly_sel (dly_sel),
        .inv_en  (inv_en),
        .a_in    (a_in),
        .b_in    (b_in),
        .a_out   (a_out),
        .b_out   (b_out)
    );

    int    checks = 0;
    int    errors = 0;
    int    ncyc   = 0;
    int    hist_a[$];
    int    hist_b[$];
    int    exp_a[LANES];
    int    exp_b[LANES];
    bit    has_exp = 1'b0;
    bit    done    = 1'b0;
    string exp_tag = "";

    function automatic int lane_of(logic [VW-1:0] v, int k);
        return int'($signed(v[k*SW +: SW]));
    endfunction

    function automatic int neg_ref(int v);
        return (v == -32768) ? 32767 : -v;
    endfunction

    function automatic int pick(int mode, int n, int k);
        case (mode)
            0: return int'($signed(16'($urandom)));
            1: return 4660;
            2: begin
                case ((n + k) % 4)
                    0:       return -32768;
                    1:       return 32767;
                    2:       return -1;
                    default: return 0;
                endcase
            end
            default: return ((n * LANES + k) % 30000) - 15000;
        endcase
    endfunction

    task automatic compare(string tag, string path, int k, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s path %s lane %0d: actual %0d expected %0d", tag, path, k, act, expv);
        end
    endtask

    task automatic check_outputs();
        if (has_exp) begin
            for (int k = 0; k < LANES; k++) begin
                compare(exp_tag, "A", k, lane_of(a_out, k), exp_a[k]);
                compare(exp_tag, "B", k, lane_of(b_out, k), exp_b[k]);
            end
        end
        has_exp = 1'b0;
    endtask

    // Called at a falling edge: check last result, drive the next vector, wait one clock.
    task automatic cycle(string tag, int d, bit inv, int am, int bm);
        int wa[LANES];
        int wb[LANES];
        int base;
        check_outputs();
        base = hist_a.size();
        for (int k = 0; k < LANES; k++) begin
            wa[k] = pick(am, ncyc, k);
            wb[k] = pick(bm, ncyc, k);
            hist_a.push_back(wa[k]);
            hist_b.push_back(wb[k]);
        end
        for (int k = 0; k < LANES; k++) begin
            exp_a[k] = inv ? neg_ref(hist_a[base + k - d]) : hist_a[base + k - d];
            exp_b[k] = inv ? neg_ref(hist_b[base + k - d]) : hist_b[base + k - d];
            a_in[k*SW +: SW] = 16'(wa[k]);
            b_in[k*SW +: SW] = 16'(wb[k]);
        end
        dly_sel = 4'(d);
        inv_en  = inv;
        has_exp = 1'b1;
        exp_tag = tag;
        ncyc++;
        @(negedge clk);
    endtask

    // R1: outputs held at zero in reset with busy inputs; history restarts at zero.
    task automatic do_reset();
        check_outputs();
        rst_n   = 1'b0;
        a_in    = {8{32'hDEAD_BEEF}};
        b_in    = {8{32'h8001_7FFE}};
        dly_sel = 4'd9;
        inv_en  = 1'b1;
        repeat (2) begin
            @(negedge clk);
            for (int k = 0; k < LANES; k++) begin
                compare("R1", "A", k, lane_of(a_out, k), 0);
                compare("R1", "B", k, lane_of(b_out, k), 0);
            end
        end
        hist_a.delete();
        hist_b.delete();
        for (int k = 0; k < LANES; k++) begin
            hist_a.push_back(0);
            hist_b.push_back(0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        repeat (20) cycle("R2,R10", 0, 1'b0, 0, 0);
        for (int d = 1; d <= 14; d++) begin
            repeat (4) cycle("R3", d, 1'b0, 3, 0);
        end
        repeat (10) cycle("R4", 15, 1'b0, 0, 3);
        repeat (12) cycle("R5", int'($urandom % 16), 1'b0, 0, 1);
        repeat (12) cycle("R5", int'($urandom % 16), 1'b0, 1, 3);
        repeat (30) cycle("R8", int'($urandom % 16), 1'b0, 0, 0);
        repeat (20) cycle("R6", int'($urandom % 16), 1'b1, 0, 0);
        for (int i = 0; i < 16; i++) begin
            cycle("R9", 5, bit'(i % 2), 3, 0);
        end
        repeat (16) cycle("R7", int'($urandom % 16), 1'b1, 2, 2);
        repeat (4) cycle("R7", 0, 1'b1, 2, 2);
        do_reset();
        repeat (10) cycle("R3", 7, 1'b0, 3, 3);
        check_outputs();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule